// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter

This block is the sending half of a simple asynchronous serial port that software drives through a small word-addressed register window. Software places bytes into an eight-entry queue by writing the data register. A serializer takes them from the queue one at a time and sends each on the `txd` line as an asynchronous frame. The bit rate comes from a programmable clock divisor. The frame has eight data bits and one or two stop bits. There is no parity and no break.

Software paces itself in one of two ways. It can read the full flag in bit 31 of the data register, or it can use an interrupt. The interrupt is raised while the queue holds fewer entries than a programmable threshold, and only when its enable bit is set. With a threshold of 1, the interrupt means "queue empty". The last frame may still be on the wire at that point, and no status bit reports when the shifter has finished.

Register offsets are byte offsets on `bus_addr`:

| Offset | Register | Fields |
|--------|----------|--------|
| 0x00 | data | write: bits 7:0 go into the queue; read: bit 31 is the full flag |
| 0x08 | control | bit 0 enables sending; bit 1 selects two stop bits; bits 18:16 hold the threshold |
| 0x10 | interrupt enable | bit 0 |
| 0x14 | interrupt pending | bit 0, read-only |
| 0x18 | divisor | bits 15:0 |

Top module: `uart_txpath`

## Requirements
- R1: After reset, `txd` is 1 and `irq` is 0. The control, interrupt-enable, pending and divisor registers read 0, and the full flag (bit 31 at offset 0x00) reads 0.
- R2: Each frame is sent in this order: one low start bit, then the eight data bits least-significant bit first, then a high stop bit. Every bit lasts divisor+1 clock cycles, where the divisor is bits 15:0 at offset 0x18. While no frame is being sent, `txd` is high.
- R3: The queue holds 8 bytes and sends them in the order they were written. Bit 31 at offset 0x00 reads 1 exactly when the queue holds 8 entries.
- R4: A write to offset 0x00 while the queue is full is dropped. The byte is never sent, and the bytes already in the queue are not changed.
- R5: Bit 1 at offset 0x08 selects the number of stop bits: 0 gives one, 1 gives two. When frames are sent back to back, each frame starts 10 bit periods after the one before it with one stop bit, or 11 bit periods after it with two.
- R6: While bit 0 at offset 0x08 is 0, no new frame starts. A frame that is already being sent runs to its end. Queued bytes wait until sending is enabled again.
- R7: Bit 0 at offset 0x14 reads 1 exactly while the number of queued bytes is less than the threshold in bits 18:16 at offset 0x08. Writes to offset 0x14 have no effect.
- R8: `irq` is high exactly when the pending bit (bit 0 at 0x14) and the enable bit (bit 0 at 0x10) are both 1.
- R9: The control fields, the enable bit and the divisor read back as written. Offsets outside the map read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| txd | output | 1 | Serial output line, idles high |
| irq | output | 1 | Threshold interrupt |

## Verification
A wrong queue count shows up on the pending bit and on the full flag in the same cycle as the write or pop that corrupted it. Lost, duplicated or reordered bytes show up at the line decoder one frame time later. A corrupted bit counter or divisor counter shows up as a misplaced stop bit or a wrong start-to-start spacing in the very next frame. The spacing of back-to-back frames is checked to the exact cycle. This catches any stray idle cycle between frames, and any stop bit that is missing or extra.

// File: rtl/uart_txpath_pkg.sv
package uart_txpath_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_IE   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_IP   = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h18;

  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_STOP2 = 1;
  localparam int unsigned WM_LSB    = 16;
  localparam int unsigned BIT_FULL  = 31;
endpackage

// File: rtl/uart_txpath_fifo.sv
module uart_txpath_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end
endmodule

// File: rtl/uart_txpath_shifter.sv
module uart_txpath_shifter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16,
  localparam int unsigned FRAME_W = DATA_W + 3,
  localparam int unsigned LEFT_W  = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              two_stop,
  input  logic [DIV_W-1:0]  div,
  input  logic              src_empty,
  input  logic [DATA_W-1:0] src_data,
  output logic              pop,
  output logic              busy,
  output logic              txd
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [DIV_W-1:0]   tick_q, tick_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               busy_q, busy_d;
  logic               bit_end, frame_end, load;

  assign bit_end   = busy_q && (tick_q == '0);
  assign frame_end = bit_end && (left_q == '0);
  assign load      = en && !src_empty && (!busy_q || frame_end);

  always_comb begin
    sh_d   = sh_q;
    tick_d = tick_q;
    left_d = left_q;
    busy_d = busy_q;
    if (load) begin
      busy_d = 1'b1;
      sh_d   = {2'b11, src_data, 1'b0};
      tick_d = div;
      left_d = two_stop ? LEFT_W'(FRAME_W - 1) : LEFT_W'(FRAME_W - 2);
    end else if (frame_end) begin
      busy_d = 1'b0;
      sh_d   = '1;
    end else if (bit_end) begin
      sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
      tick_d = div;
      left_d = left_q - 1'b1;
    end else if (busy_q) begin
      tick_d = tick_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      tick_q <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      tick_q <= tick_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign pop  = load;
  assign busy = busy_q;
  assign txd  = sh_q[0];
endmodule

// File: rtl/uart_txpath.sv
module uart_txpath
  import uart_txpath_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned WM_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              txd,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned CMP_W = CNT_W + WM_W;

  logic             rst_meta_q, rst_sync_q;
  logic             ctrl_en_q, ctrl_en_d, stop2_q, stop2_d, ie_tx_q, ie_tx_d;
  logic [WM_W-1:0]  wm_q, wm_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             data_wr, ctrl_wr, ie_wr, div_wr;
  logic [CNT_W-1:0] fifo_count;
  logic             fifo_full, fifo_empty, fifo_pop, shift_busy, tx_pend;
  logic [DATA_W-1:0] fifo_head;
  logic             unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign data_wr = bus_sel && bus_wr && (bus_addr == OFS_DATA);
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign ie_wr   = bus_sel && bus_wr && (bus_addr == OFS_IE);
  assign div_wr  = bus_sel && bus_wr && (bus_addr == OFS_DIV);
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    ctrl_en_d = ctrl_wr ? bus_wdata[BIT_EN]           : ctrl_en_q;
    stop2_d   = ctrl_wr ? bus_wdata[BIT_STOP2]        : stop2_q;
    wm_d      = ctrl_wr ? bus_wdata[WM_LSB +: WM_W]   : wm_q;
    ie_tx_d   = ie_wr   ? bus_wdata[0]                : ie_tx_q;
    div_d     = div_wr  ? bus_wdata[DIV_W-1:0]        : div_q;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      ctrl_en_q <= 1'b0;
      stop2_q   <= 1'b0;
      wm_q      <= '0;
      ie_tx_q   <= 1'b0;
      div_q     <= '0;
    end else begin
      ctrl_en_q <= ctrl_en_d;
      stop2_q   <= stop2_d;
      wm_q      <= wm_d;
      ie_tx_q   <= ie_tx_d;
      div_q     <= div_d;
    end
  end

  uart_txpath_fifo #(.DEPTH(DEPTH), .W(DATA_W)) fifo_i (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .push  (data_wr),
    .wdata (bus_wdata[DATA_W-1:0]),
    .pop   (fifo_pop),
    .rdata (fifo_head),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  uart_txpath_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .en        (ctrl_en_q),
    .two_stop  (stop2_q),
    .div       (div_q),
    .src_empty (fifo_empty),
    .src_data  (fifo_head),
    .pop       (fifo_pop),
    .busy      (shift_busy),
    .txd       (txd)
  );

  assign tx_pend = CMP_W'(fifo_count) < CMP_W'(wm_q);
  assign irq     = tx_pend && ie_tx_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA: bus_rdata[BIT_FULL] = fifo_full;
      OFS_CTRL: begin
        bus_rdata[BIT_EN]         = ctrl_en_q;
        bus_rdata[BIT_STOP2]      = stop2_q;
        bus_rdata[WM_LSB +: WM_W] = wm_q;
      end
      OFS_IE:   bus_rdata[0] = ie_tx_q;
      OFS_IP:   bus_rdata[0] = tx_pend;
      OFS_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_txpath_chk.sv
module uart_txpath_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             irq,
  input logic             busy,
  input logic             en,
  input logic             ie,
  input logic             pend,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_full,
  input logic             push_req,
  input logic             pop
);
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  // R4
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_full && !pop) |=> $stable(fifo_count));

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R6
  no_start_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !busy);

  // R7
  full_never_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CNT_W'(DEPTH)) |-> !pend);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);
endmodule

bind uart_txpath uart_txpath_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .txd        (txd),
  .irq        (irq),
  .busy       (shift_busy),
  .en         (ctrl_en_q),
  .ie         (ie_tx_q),
  .pend       (tx_pend),
  .fifo_count (fifo_count),
  .fifo_full  (fifo_full),
  .push_req   (data_wr),
  .pop        (fifo_pop)
);

// File: tb/uart_txpath_tb.sv
module uart_txpath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_DIV     = 3;
  localparam int BP         = TB_DIV + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, irq;

  int checks = 0, fails = 0, cyc = 0;
  bit mon_two = 1'b0;
  logic [7:0] exp_q [$];

  uart_txpath dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    wr(5'h00, {24'h0, b});
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (3 * BP) @(negedge clk);
  endtask

  // Monitor: decodes frames on txd and compares with the scoreboard queue
  initial begin
    int prev_start;
    bit have_prev;
    logic [7:0] got;
    have_prev = 1'b0;
    prev_start = 0;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        if (have_prev && (cyc - prev_start) < 12 * BP)
          chk((cyc - prev_start) == (mon_two ? 11 : 10) * BP, "R5 frame spacing",
              cyc - prev_start, (mon_two ? 11 : 10) * BP);
        prev_start = cyc;
        have_prev = 1'b1;
        repeat (BP/2) @(negedge clk);
        chk(txd === 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BP) @(negedge clk);
          got[i] = txd;
        end
        repeat (BP) @(negedge clk);
        chk(txd === 1'b1, "R2 stop bit", txd, 1);
        if (mon_two) begin
          repeat (BP) @(negedge clk);
          chk(txd === 1'b1, "R5 second stop bit", txd, 1);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4/R6 unexpected frame", got, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(got === e, "R2/R3 frame data", got, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    bit stayed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1, "R1 txd idle", txd, 1);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    rd(5'h08, v); chk(v === 32'h0, "R1 ctrl", v, 0);
    rd(5'h00, v); chk(v === 32'h0, "R1 full flag", v, 0);
    rd(5'h10, v); chk(v === 32'h0, "R1 ie", v, 0);
    rd(5'h14, v); chk(v === 32'h0, "R1 pending", v, 0);
    rd(5'h18, v); chk(v === 32'h0, "R1 divisor", v, 0);

    // R9 readback, unmapped, read-only pending
    wr(5'h18, 32'hFFFF_0000 | TB_DIV);
    rd(5'h18, v); chk(v === TB_DIV, "R9 divisor readback", v, TB_DIV);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, v); chk(v === 32'h0, "R9 unmapped", v, 0);
    wr(5'h14, 32'h1);
    rd(5'h14, v); chk(v === 32'h0, "R7 pending write ignored", v, 0);

    // One stop bit, threshold 1, enabled
    wr(5'h08, 32'h0001_0001);
    rd(5'h08, v); chk(v === 32'h0001_0001, "R9 ctrl readback", v, 32'h0001_0001);
    rd(5'h14, v); chk(v === 32'h1, "R7 empty below level 1", v, 1);
    chk(irq === 1'b0, "R8 irq masked", irq, 0);
    wr(5'h10, 32'h1);
    rd(5'h10, v); chk(v === 32'h1, "R9 ie readback", v, 1);
    chk(irq === 1'b1, "R8 irq enabled", irq, 1);
    send(8'hA5); send(8'h3C); send(8'h01); send(8'h80); send(8'hFF); send(8'h00);
    drain();
    chk(irq === 1'b1, "R8 irq after drain", irq, 1);

    // R5 two stop bits
    mon_two = 1'b1;
    wr(5'h08, 32'h0001_0003);
    send(8'h5A); send(8'hC3); send(8'h7E);
    drain();
    mon_two = 1'b0;

    // R3/R4/R6/R7 disabled fill, threshold 4
    wr(5'h08, 32'h0004_0000);
    send(8'h11); send(8'h22); send(8'h33);
    rd(5'h14, v); chk(v === 32'h1, "R7 three below four", v, 1);
    chk(irq === 1'b1, "R8 irq pending", irq, 1);
    send(8'h44);
    rd(5'h14, v); chk(v === 32'h0, "R7 four not below four", v, 0);
    chk(irq === 1'b0, "R8 irq cleared", irq, 0);
    rd(5'h00, v); chk(v[31] === 1'b0, "R3 not full at four", v, 0);
    send(8'h55); send(8'h66); send(8'h77); send(8'h88);
    rd(5'h00, v); chk(v[31] === 1'b1, "R3 full at eight", v, 32'h8000_0000);
    wr(5'h00, 32'hEE);
    stayed = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) stayed = 1'b0;
    end
    chk(stayed, "R6 no frame while disabled", stayed, 1);
    wr(5'h10, 32'h0);
    wr(5'h08, 32'h0004_0001);
    drain();
    repeat (20 * BP) @(negedge clk);
    chk(exp_q.size() == 0, "R4 dropped byte not sent", exp_q.size(), 0);
    rd(5'h14, v); chk(v === 32'h1, "R7 empty below four", v, 1);
    chk(irq === 1'b0, "R8 irq masked after drain", irq, 0);
    rd(5'h00, v); chk(v === 32'h0, "R3 full flag clear", v, 0);

    // R6 disable mid-frame: current frame finishes, next waits
    wr(5'h08, 32'h0001_0001);
    send(8'h96);
    wr(5'h00, 32'h69);
    wr(5'h08, 32'h0001_0000);
    repeat (15 * BP) @(negedge clk);
    chk(exp_q.size() == 0, "R6 running frame completes", exp_q.size(), 0);
    chk(txd === 1'b1, "R6 line idle while held", txd, 1);
    exp_q.push_back(8'h69);
    wr(5'h08, 32'h0001_0001);
    drain();
    chk(exp_q.size() == 0, "R6 held byte sent on enable", exp_q.size(), 0);

    finish_run();
  end
endmodule